// File: doc/BRIEF.md
# Atomic Reservation and RMW Pairing Monitor

This block watches the request stream of one processor port on its way to the data cache controller. It tracks two kinds of atomic activity. The first is a load-linked / store-conditional style reservation: one register holds a line address and the ID of the processor that owns it. The second is a read-modify-write sequence: counters pair each atomic read with its atomic write.

Each issued request carries a kind, a line address and an owner ID. Each completion event carries the same three fields. Every output is registered and changes one clock after the event that causes it. On a conditional store, the block reports success or failure and takes the reservation away. It tells the cache controller which request class to use, and it holds back a conditional store that has failed. It also sends pin-line and unpin-line commands when atomic reads and writes complete. When an ordinary access breaks into an atomic sequence, it sends a command to unpin every atomic line, or it raises a warning. A sticky error output records any broken pairing rule.

Request kind encoding, used on `req_kind` and `cpl_kind`: 0 load, 1 store, 2 instruction fetch, 3 locked read, 4 locked write (conditional store), 5 RMW read, 6 RMW write, 7 no operation.

Top module: `atomic_monitor`

## Requirements
- R1: At reset, the reservation is invalid, all pulse outputs and `err` are 0, and both pairing counts are 0.
- R2: A locked-read completion (`cpl_kind`=3) makes the reservation valid, with `cpl_line` and `cpl_owner` stored in it, one cycle later.
- R3: A locked-write issue (`req_kind`=4) pulses `sc_done` one cycle later. `sc_ok` is 1 only if the reservation was valid with the same line and the same owner. Whatever the outcome, a reservation on the same line becomes invalid. A reservation on a different line stays valid.
- R4: A failed locked write is not forwarded: `ctrl_valid` stays 0 in that cycle. A successful one is forwarded with class atomic.
- R5: An RMW-read completion pulses `pin_set`, and an RMW-write completion pulses `pin_clr`. In both cases `pin_line` carries the completion line, one cycle later.
- R6: A legal RMW read increments `pend_rd`. A legal RMW write increments `pend_wr`. When `pend_wr` would reach `pend_rd`, both counts return to 0.
- R7: A load, store or fetch issued while `pend_rd`>0 and `pend_wr`=0 pulses `pin_reset_all` and clears both counts. With both counts at 0, it pulses neither `pin_reset_all` nor `warn`.
- R8: A load, store or fetch issued while `pend_wr`>0 pulses `warn` (and not `pin_reset_all`) and clears both counts.
- R9: The following are pairing violations: an RMW read while `pend_wr`>0, an RMW read with `pend_rd` at its maximum, and an RMW write with `pend_rd`=0. A violation sets `err`, which stays 1 until reset, and leaves the counts unchanged.
- R10: Forwarded class on `ctrl_class`: load→0, store→1, fetch→2, and locked read, locked write, RMW read and RMW write→3. Kind 7 is not forwarded and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request issued this cycle |
| req_kind | input | 3 | Issued request kind |
| req_line | input | LINE_W | Issued line address |
| req_owner | input | ID_W | Issuing processor ID |
| cpl_valid | input | 1 | Completion event this cycle |
| cpl_kind | input | 3 | Completed request kind |
| cpl_line | input | LINE_W | Completed line address |
| cpl_owner | input | ID_W | Processor ID of completion |
| resv_valid | output | 1 | Reservation held |
| resv_line | output | LINE_W | Reserved line |
| resv_owner | output | ID_W | Reservation owner |
| sc_done | output | 1 | Conditional store resolved |
| sc_ok | output | 1 | Conditional store succeeded |
| ctrl_valid | output | 1 | Request forwarded to cache controller |
| ctrl_class | output | 2 | Forwarded request class |
| pin_set | output | 1 | Pin line command |
| pin_clr | output | 1 | Unpin line command |
| pin_line | output | LINE_W | Line for pin commands |
| pin_reset_all | output | 1 | Unpin all lines command |
| pend_rd | output | CNT_W | Outstanding RMW reads |
| pend_wr | output | CNT_W | RMW writes matched so far |
| warn | output | 1 | Interrupted partial RMW sequence |
| err | output | 1 | Sticky pairing violation |

## Verification
A corrupted reservation register shows up on `resv_*` one cycle after the completion that wrote it. It then shows up as a wrong `sc_ok` on the next conditional store, and the `ctrl_valid` of that same cycle is wrong too. A wrong pairing count is visible at once on `pend_rd` and `pend_wr`. A wrong count also sends the next ordinary access down the wrong branch: `pin_reset_all` fires where `warn` should, or the other way round, or neither fires. It can also raise `err` on a legal RMW write.

// File: rtl/atomic_monitor_pkg.sv
`timescale 1ns/1ps
package atomic_monitor_pkg;
  localparam logic [2:0] K_LOAD  = 3'd0;
  localparam logic [2:0] K_STORE = 3'd1;
  localparam logic [2:0] K_FETCH = 3'd2;
  localparam logic [2:0] K_LRD   = 3'd3;
  localparam logic [2:0] K_LWR   = 3'd4;
  localparam logic [2:0] K_RRD   = 3'd5;
  localparam logic [2:0] K_RWR   = 3'd6;
  localparam logic [2:0] K_NONE  = 3'd7;

  typedef enum logic [1:0] {
    CLS_READ   = 2'd0,
    CLS_WRITE  = 2'd1,
    CLS_FETCH  = 2'd2,
    CLS_ATOMIC = 2'd3
  } req_class_e;

  function automatic req_class_e kind_to_class(input logic [2:0] k);
    case (k)
      K_LOAD:  return CLS_READ;
      K_STORE: return CLS_WRITE;
      K_FETCH: return CLS_FETCH;
      default: return CLS_ATOMIC;
    endcase
  endfunction
endpackage

// File: rtl/resv_unit.sv
`timescale 1ns/1ps
module resv_unit #(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lwr_issue,
  input  logic [LINE_W-1:0] lwr_line,
  input  logic [ID_W-1:0]   lwr_owner,
  input  logic              lrd_done,
  input  logic [LINE_W-1:0] lrd_line,
  input  logic [ID_W-1:0]   lrd_owner,
  output logic              pass_now,
  output logic              held,
  output logic [LINE_W-1:0] held_line,
  output logic [ID_W-1:0]   held_owner,
  output logic              cond_done,
  output logic              cond_ok
);
  logic same_line;
  assign same_line = held && (held_line == lwr_line);
  assign pass_now  = same_line && (held_owner == lwr_owner);

  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= 1'b0;
      held_line  <= '0;
      held_owner <= '0;
      cond_done  <= 1'b0;
      cond_ok    <= 1'b0;
    end else begin
      cond_done <= lwr_issue;
      cond_ok   <= lwr_issue && pass_now;
      if (lwr_issue && same_line) held <= 1'b0;
      if (lrd_done) begin
        held       <= 1'b1;
        held_line  <= lrd_line;
        held_owner <= lrd_owner;
      end
    end
  end

  // R3
  ok_needs_resv_chk: assert property (@(posedge clk) disable iff (rst)
    cond_ok |-> ($past(held) && cond_done));
  // R3
  sc_consumes_resv_chk: assert property (@(posedge clk) disable iff (rst)
    (lwr_issue && pass_now && !lrd_done) |=> !held);
endmodule

// File: rtl/rmw_pairing.sv
`timescale 1ns/1ps
module rmw_pairing #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_issue,
  input  logic             wr_issue,
  input  logic             plain_issue,
  output logic [CNT_W-1:0] rd_cnt,
  output logic [CNT_W-1:0] wr_cnt,
  output logic             unpin_all,
  output logic             warn,
  output logic             err
);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic rd_bad, wr_bad, wr_closes;
  assign rd_bad    = (wr_cnt != '0) || (rd_cnt == CNT_MAX);
  assign wr_bad    = (rd_cnt == '0) || (wr_cnt >= rd_cnt);
  assign wr_closes = ((wr_cnt + ONE) == rd_cnt);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt    <= '0;
      wr_cnt    <= '0;
      unpin_all <= 1'b0;
      warn      <= 1'b0;
      err       <= 1'b0;
    end else begin
      unpin_all <= 1'b0;
      warn      <= 1'b0;
      if (rd_issue) begin
        if (rd_bad) err <= 1'b1;
        else        rd_cnt <= rd_cnt + ONE;
      end else if (wr_issue) begin
        if (wr_bad) err <= 1'b1;
        else if (wr_closes) begin
          rd_cnt <= '0;
          wr_cnt <= '0;
        end else wr_cnt <= wr_cnt + ONE;
      end else if (plain_issue) begin
        if (rd_cnt != '0 && wr_cnt == '0) begin
          unpin_all <= 1'b1;
          rd_cnt    <= '0;
        end else if (wr_cnt != '0) begin
          warn   <= 1'b1;
          rd_cnt <= '0;
          wr_cnt <= '0;
        end
      end
    end
  end

  // R6
  wr_not_ahead_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt <= rd_cnt);
  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
  // R8
  warn_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(warn && unpin_all));
  // R8
  warn_cause_chk: assert property (@(posedge clk) disable iff (rst)
    warn |-> ($past(wr_cnt) != '0));
endmodule

// File: rtl/class_encoder.sv
`timescale 1ns/1ps
module class_encoder
  import atomic_monitor_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_kind,
  input  logic       cond_pass,
  output logic       fwd_valid,
  output logic [1:0] fwd_class
);
  logic blocked;
  assign blocked = (req_kind == K_NONE) || ((req_kind == K_LWR) && !cond_pass);

  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_valid <= 1'b0;
      fwd_class <= CLS_READ;
    end else begin
      fwd_valid <= req_valid && !blocked;
      if (req_valid) fwd_class <= kind_to_class(req_kind);
    end
  end
endmodule

// File: rtl/atomic_monitor.sv
`timescale 1ns/1ps
module atomic_monitor
  import atomic_monitor_pkg::*;
#(
  parameter int LINE_W = 26,
  parameter int ID_W   = 4,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [LINE_W-1:0] req_line,
  input  logic [ID_W-1:0]   req_owner,
  input  logic              cpl_valid,
  input  logic [2:0]        cpl_kind,
  input  logic [LINE_W-1:0] cpl_line,
  input  logic [ID_W-1:0]   cpl_owner,
  output logic              resv_valid,
  output logic [LINE_W-1:0] resv_line,
  output logic [ID_W-1:0]   resv_owner,
  output logic              sc_done,
  output logic              sc_ok,
  output logic              ctrl_valid,
  output logic [1:0]        ctrl_class,
  output logic              pin_set,
  output logic              pin_clr,
  output logic [LINE_W-1:0] pin_line,
  output logic              pin_reset_all,
  output logic [CNT_W-1:0]  pend_rd,
  output logic [CNT_W-1:0]  pend_wr,
  output logic              warn,
  output logic              err
);
  logic iss_lwr, iss_rrd, iss_rwr, iss_plain, cpl_lrd, cpl_rrd, cpl_rwr, pass_now;

  assign iss_lwr   = req_valid && (req_kind == K_LWR);
  assign iss_rrd   = req_valid && (req_kind == K_RRD);
  assign iss_rwr   = req_valid && (req_kind == K_RWR);
  assign iss_plain = req_valid && (req_kind <= K_FETCH);
  assign cpl_lrd   = cpl_valid && (cpl_kind == K_LRD);
  assign cpl_rrd   = cpl_valid && (cpl_kind == K_RRD);
  assign cpl_rwr   = cpl_valid && (cpl_kind == K_RWR);

  resv_unit #(.LINE_W(LINE_W), .ID_W(ID_W)) u_resv (
    .clk(clk), .rst(rst),
    .lwr_issue(iss_lwr), .lwr_line(req_line), .lwr_owner(req_owner),
    .lrd_done(cpl_lrd), .lrd_line(cpl_line), .lrd_owner(cpl_owner),
    .pass_now(pass_now),
    .held(resv_valid), .held_line(resv_line), .held_owner(resv_owner),
    .cond_done(sc_done), .cond_ok(sc_ok)
  );

  rmw_pairing #(.CNT_W(CNT_W)) u_pair (
    .clk(clk), .rst(rst),
    .rd_issue(iss_rrd), .wr_issue(iss_rwr), .plain_issue(iss_plain),
    .rd_cnt(pend_rd), .wr_cnt(pend_wr),
    .unpin_all(pin_reset_all), .warn(warn), .err(err)
  );

  class_encoder u_cls (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .cond_pass(pass_now),
    .fwd_valid(ctrl_valid), .fwd_class(ctrl_class)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_set  <= 1'b0;
      pin_clr  <= 1'b0;
      pin_line <= '0;
    end else begin
      pin_set <= cpl_rrd;
      pin_clr <= cpl_rwr;
      if (cpl_rrd || cpl_rwr) pin_line <= cpl_line;
    end
  end

  // R4
  failed_sc_blocked_chk: assert property (@(posedge clk) disable iff (rst)
    (sc_done && !sc_ok) |-> !ctrl_valid);
  // R4
  good_sc_atomic_chk: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> (ctrl_valid && ctrl_class == CLS_ATOMIC));
  // R5
  pin_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(pin_set && pin_clr));
  // R5
  pin_cause_chk: assert property (@(posedge clk) disable iff (rst)
    pin_set |-> $past(cpl_valid));
endmodule

// File: tb/atomic_monitor_bench.sv
`timescale 1ns/1ps
module atomic_monitor_bench;
  localparam int LW = 26;
  localparam int IW = 4;
  localparam int CW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, cpl_valid = 1'b0;
  logic [2:0] req_kind = 3'd7, cpl_kind = 3'd7;
  logic [LW-1:0] req_line = '0, cpl_line = '0;
  logic [IW-1:0] req_owner = '0, cpl_owner = '0;
  logic resv_valid, sc_done, sc_ok, ctrl_valid, pin_set, pin_clr, pin_reset_all, warn, err;
  logic [LW-1:0] resv_line, pin_line;
  logic [IW-1:0] resv_owner;
  logic [1:0] ctrl_class;
  logic [CW-1:0] pend_rd, pend_wr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  atomic_monitor #(.LINE_W(LW), .ID_W(IW), .CNT_W(CW)) u_atomic_monitor (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_kind(req_kind), .req_line(req_line), .req_owner(req_owner),
    .cpl_valid(cpl_valid), .cpl_kind(cpl_kind), .cpl_line(cpl_line), .cpl_owner(cpl_owner),
    .resv_valid(resv_valid), .resv_line(resv_line), .resv_owner(resv_owner),
    .sc_done(sc_done), .sc_ok(sc_ok), .ctrl_valid(ctrl_valid), .ctrl_class(ctrl_class),
    .pin_set(pin_set), .pin_clr(pin_clr), .pin_line(pin_line), .pin_reset_all(pin_reset_all),
    .pend_rd(pend_rd), .pend_wr(pend_wr), .warn(warn), .err(err)
  );

  // {kind, expected forward, expected class}
  localparam logic [5:0] VEC [8] = '{
    {3'd0, 1'b1, 2'd0}, {3'd1, 1'b1, 2'd1}, {3'd2, 1'b1, 2'd2}, {3'd3, 1'b1, 2'd3},
    {3'd4, 1'b0, 2'd0}, {3'd5, 1'b1, 2'd3}, {3'd6, 1'b1, 2'd3}, {3'd7, 1'b0, 2'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive one cycle of stimulus; returns at the next negedge with outputs settled
  task automatic step(input logic iv, input logic [2:0] ik, input logic [LW-1:0] il,
                      input logic [IW-1:0] io, input logic cv, input logic [2:0] ck,
                      input logic [LW-1:0] cl, input logic [IW-1:0] co);
    req_valid = iv; req_kind = ik; req_line = il; req_owner = io;
    cpl_valid = cv; cpl_kind = ck; cpl_line = cl; cpl_owner = co;
    @(negedge clk);
    req_valid = 1'b0; cpl_valid = 1'b0;
  endtask

  task automatic issue(input logic [2:0] k, input logic [LW-1:0] l, input logic [IW-1:0] o);
    step(1'b1, k, l, o, 1'b0, 3'd7, '0, '0);
  endtask

  task automatic complete(input logic [2:0] k, input logic [LW-1:0] l, input logic [IW-1:0] o);
    step(1'b0, 3'd7, '0, '0, 1'b1, k, l, o);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 resv_valid", resv_valid, 0);
    chk("R1 err", err, 0);
    chk("R1 pend_rd", pend_rd, 0);
    chk("R1 pend_wr", pend_wr, 0);
    chk("R1 pulses", {sc_done, ctrl_valid, pin_set, pin_clr, pin_reset_all, warn}, 0);

    // R10 class table walk
    for (int i = 0; i < 8; i++) begin
      issue(VEC[i][5:3], 26'h5, 4'd1);
      chk("R10 fwd valid", ctrl_valid, VEC[i][2]);
      if (VEC[i][2]) chk("R10 class", ctrl_class, VEC[i][1:0]);
    end
    chk("R10 counts after table", {pend_rd, pend_wr, err}, 0);

    // R2 reservation
    complete(3'd3, 26'h12, 4'd3);
    chk("R2 valid", resv_valid, 1);
    chk("R2 line", resv_line, 26'h12);
    chk("R2 owner", resv_owner, 3);

    // R3/R4 successful conditional store
    issue(3'd4, 26'h12, 4'd3);
    chk("R3 done", sc_done, 1);
    chk("R3 ok", sc_ok, 1);
    chk("R4 fwd", {ctrl_valid, ctrl_class}, 3'b111);
    chk("R3 cleared", resv_valid, 0);
    // R3/R4 second attempt fails
    issue(3'd4, 26'h12, 4'd3);
    chk("R3 fail ok", {sc_done, sc_ok}, 2'b10);
    chk("R4 blocked", ctrl_valid, 0);

    // R3 foreign owner fails and clears
    complete(3'd3, 26'h20, 4'd3);
    issue(3'd4, 26'h20, 4'd5);
    chk("R3 foreign owner", {sc_done, sc_ok}, 2'b10);
    chk("R3 foreign clears", resv_valid, 0);
    // R3 other line fails, reservation kept
    complete(3'd3, 26'h30, 4'd3);
    issue(3'd4, 26'h31, 4'd3);
    chk("R3 other line", {sc_done, sc_ok}, 2'b10);
    chk("R3 other line keeps", {resv_valid, resv_line}, {1'b1, 26'h30});

    // R5 pin commands
    complete(3'd5, 26'h40, 4'd0);
    chk("R5 pin_set", {pin_set, pin_clr}, 2'b10);
    chk("R5 line", pin_line, 26'h40);
    complete(3'd6, 26'h41, 4'd0);
    chk("R5 pin_clr", {pin_set, pin_clr}, 2'b01);
    chk("R5 clr line", pin_line, 26'h41);

    // R6 pairing
    issue(3'd5, 26'h50, 4'd1);
    issue(3'd5, 26'h50, 4'd1);
    chk("R6 two reads", pend_rd, 2);
    issue(3'd6, 26'h50, 4'd1);
    chk("R6 one write", {pend_rd, pend_wr}, {3'd2, 3'd1});
    issue(3'd6, 26'h50, 4'd1);
    chk("R6 balanced", {pend_rd, pend_wr, err}, 0);

    // R7 plain access with nothing pending
    issue(3'd0, 26'h1, 4'd1);
    chk("R7 idle plain", {pin_reset_all, warn}, 0);
    // R7 interrupt after reads only
    issue(3'd5, 26'h60, 4'd1);
    issue(3'd2, 26'h61, 4'd1);
    chk("R7 reset_all", {pin_reset_all, warn}, 2'b10);
    chk("R7 counts", {pend_rd, pend_wr}, 0);

    // R8 interrupt mid-write
    issue(3'd5, 26'h70, 4'd1);
    issue(3'd5, 26'h70, 4'd1);
    issue(3'd6, 26'h70, 4'd1);
    issue(3'd1, 26'h71, 4'd1);
    chk("R8 warn", {pin_reset_all, warn}, 2'b01);
    chk("R8 counts", {pend_rd, pend_wr}, 0);
    chk("R8 no err", err, 0);

    // R9 write with no read
    issue(3'd6, 26'h80, 4'd1);
    chk("R9 orphan write", {err, pend_rd, pend_wr}, {1'b1, 6'd0});
    issue(3'd0, 26'h80, 4'd1);
    chk("R9 sticky", err, 1);
    do_reset();
    chk("R9 reset clears", err, 0);
    // R9 read after write started
    issue(3'd5, 26'h90, 4'd1);
    issue(3'd5, 26'h90, 4'd1);
    issue(3'd6, 26'h90, 4'd1);
    issue(3'd5, 26'h90, 4'd1);
    chk("R9 read after write", {err, pend_rd, pend_wr}, {1'b1, 3'd2, 3'd1});
    do_reset();
    // R9 read counter full
    for (int i = 0; i < 7; i++) issue(3'd5, 26'hA0, 4'd1);
    chk("R9 full no err", {err, pend_rd}, {1'b0, 3'd7});
    issue(3'd5, 26'hA0, 4'd1);
    chk("R9 overflow", {err, pend_rd}, {1'b1, 3'd7});

    // R10 kind 7 has no effect
    do_reset();
    issue(3'd5, 26'hB0, 4'd1);
    issue(3'd7, 26'hB0, 4'd1);
    chk("R10 nop", {ctrl_valid, pin_reset_all, warn, pend_rd}, {3'b000, 3'd1});

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule